// File: doc/BRIEF.md
# Load/Store Operand Addressing Unit

This block resolves the source operand of a load-type instruction and places it in a destination register. It receives a 16-bit instruction word, a 3-bit addressing-mode code and a one-cycle start strobe. From these it works out the effective address or the constant. It issues as many reads as the mode needs on a synchronous memory read port, and it writes the final value through a write port into an external four-entry register file. It reads the register file through a combinational read port whenever a mode takes its base from a register.

Six modes are supported:
- Immediate constant.
- Direct memory address.
- Memory-held pointer, which needs two reads.
- Register-to-register copy.
- Register-held address.
- Register-held address plus a small unsigned offset.

Every computed address is cut to the memory address width. The unit handles one instruction at a time. A single-cycle done pulse marks the cycle in which the destination register is written.

Memory modes (0, 1, 2) take the destination register from bits 11..10 and the address or constant from bits 9..0. Register modes (3, 4, 5) take the destination from bits 9..8, the source register from bits 5..4 and the offset from bits 3..0. Bits 15..12 carry the opcode, which this unit does not interpret. Latency is counted in clock edges, starting from the edge at which start is sampled and ending at the edge at which the register file is written.

Top module: `opnd_resolve_unit`

## Requirements
- R1: Mode 1 (immediate) writes bits 9..0 of the instruction, zero-extended to 16 bits, into register bits 11..10. It makes no memory read, and done is high in the cycle right after the start edge.
- R2: Mode 0 (direct) reads memory at bits 9..0 and writes the returned word into register bits 11..10. It makes one read, and the write happens 3 cycles after the start edge.
- R3: Mode 2 (indirect) reads memory at bits 9..0 and uses the low 10 bits of the returned word as the address of a second read. It writes the second word into register bits 11..10. It makes exactly two reads, and the write happens 5 cycles after the start edge.
- R4: Mode 3 (register copy) writes the contents of register bits 5..4 into register bits 9..8. It makes no memory read, and the write happens 2 cycles after the start edge.
- R5: Mode 4 (register-held address) reads memory at the low 10 bits of register bits 5..4 and ignores instruction bits 3..0. It writes the result into register bits 9..8 after one read, 4 cycles after the start edge.
- R6: Mode 5 (register plus offset) reads memory at the low 10 bits of the sum of register bits 5..4 and the zero-extended bits 3..0, so a carry past bit 9 is dropped. It writes the result into register bits 9..8 after one read, 4 cycles after the start edge.
- R7: Each memory read raises the read enable for exactly one cycle. The unit uses the returned data in the next cycle.
- R8: done is a one-cycle pulse. It is high exactly when the register-file write enable is high, and it is high once per accepted instruction.
- R9: A start strobe that arrives while an instruction is in progress is ignored. It causes no extra write and no change to the instruction in progress.
- R10: A start strobe with mode 6 or 7 is rejected: there is no read, no write and no done, and the unit stays ready for the next instruction.
- R11: While reset is low (sampled on the clock edge), done, the write enable and the read enable are low, and any instruction in progress is dropped without a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start strobe, accepted only when idle |
| instr | input | 16 | Instruction word |
| mode | input | 3 | Addressing-mode code (0..5 valid) |
| mem_rd_en | output | 1 | Memory read request |
| mem_addr | output | 10 | Memory read address |
| mem_rd_data | input | 16 | Read data, valid the cycle after the request |
| rf_rd_idx | output | 2 | Register-file read index |
| rf_rd_data | input | 16 | Register-file read data (combinational) |
| rf_we | output | 1 | Register-file write enable |
| rf_wr_idx | output | 2 | Register-file write index |
| rf_wr_data | output | 16 | Register-file write data |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach from the ports is a new start strobe that lands in the middle of a two-read pointer chase, at the moment the first returned word is about to become the second address. The stimulus starts an indirect load and then drives an immediate load on the very next cycle. It checks that only one done appears, at the indirect instruction's latency and index, and that the immediate's target register is left alone. Address truncation is reached with a stored pointer whose upper bits are set and with a register-plus-offset sum that carries past bit 9. Both cases land on memory cells whose contents differ from those an untruncated address would select.

// File: rtl/opnd_pkg.sv
// Package: shared mode codes, controller states and field widths for the
// operand addressing unit. Assumes a 16-bit instruction word.
package opnd_pkg;

    localparam int MODE_W = 3;
    localparam int OFF_W  = 4;

    localparam logic [MODE_W-1:0] AM_DIRECT  = 3'd0;
    localparam logic [MODE_W-1:0] AM_IMM     = 3'd1;
    localparam logic [MODE_W-1:0] AM_INDIR   = 3'd2;
    localparam logic [MODE_W-1:0] AM_REG     = 3'd3;
    localparam logic [MODE_W-1:0] AM_REG_IND = 3'd4;
    localparam logic [MODE_W-1:0] AM_REG_OFF = 3'd5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SRC,
        ST_ISSUE,
        ST_RETURN,
        ST_WRITE
    } ctrl_state_e;

endpackage

// File: rtl/opnd_decode.sv
// Module: opnd_decode
// Splits the instruction word into register indices, the address/constant
// field and the offset. Turns the mode code into the step plan: whether a
// source register is read, how many memory hops follow, and whether the
// mode is legal. Purely combinational; assumes REG_IDX_W <= 2 and
// ADDR_W >= OFF_W.
module opnd_decode
    import opnd_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int ADDR_W    = 10,
    parameter int REG_IDX_W = 2
) (
    input  logic [DATA_W-1:0]    instr,
    input  logic [MODE_W-1:0]    mode,
    output logic                 legal,
    output logic                 use_src,
    output logic [1:0]           hops,
    output logic [REG_IDX_W-1:0] dst_idx,
    output logic [REG_IDX_W-1:0] src_idx,
    output logic [ADDR_W-1:0]    addr_fld,
    output logic [DATA_W-1:0]    imm_val,
    output logic [OFF_W-1:0]     off_val
);

    localparam int MEM_DST_LSB = ADDR_W;
    localparam int REG_DST_LSB = 8;
    localparam int REG_SRC_LSB = 4;

    // Field extraction shared by all modes.
    always_comb begin
        src_idx  = instr[REG_SRC_LSB +: REG_IDX_W];
        addr_fld = instr[ADDR_W-1:0];
        imm_val  = {{(DATA_W-ADDR_W){1'b0}}, instr[ADDR_W-1:0]};
    end

    // Step plan per addressing mode.
    always_comb begin
        legal   = 1'b1;
        use_src = 1'b0;
        hops    = 2'd0;
        off_val = '0;
        dst_idx = instr[MEM_DST_LSB +: REG_IDX_W];
        case (mode)
            AM_DIRECT:  hops = 2'd1;
            AM_IMM:     hops = 2'd0;
            AM_INDIR:   hops = 2'd2;
            AM_REG: begin
                use_src = 1'b1;
                dst_idx = instr[REG_DST_LSB +: REG_IDX_W];
            end
            AM_REG_IND: begin
                use_src = 1'b1;
                hops    = 2'd1;
                dst_idx = instr[REG_DST_LSB +: REG_IDX_W];
            end
            AM_REG_OFF: begin
                use_src = 1'b1;
                hops    = 2'd1;
                off_val = instr[OFF_W-1:0];
                dst_idx = instr[REG_DST_LSB +: REG_IDX_W];
            end
            default:    legal = 1'b0;
        endcase
    end

endmodule

// File: rtl/opnd_addr_gen.sv
// Module: opnd_addr_gen
// Forms a memory address from a register value plus an unsigned offset,
// keeping only the low ADDR_W bits of the sum (carry out is dropped).
// Assumes DATA_W >= ADDR_W >= OFF_W.
module opnd_addr_gen
    import opnd_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 10
) (
    input  logic [DATA_W-1:0] base,
    input  logic [OFF_W-1:0]  offset,
    output logic [ADDR_W-1:0] eff_addr
);

    localparam int PAD_W = ADDR_W - OFF_W;

    // Truncated add of base and zero-extended offset.
    always_comb begin
        eff_addr = base[ADDR_W-1:0] + {{PAD_W{1'b0}}, offset};
    end

endmodule

// File: rtl/opnd_ctrl.sv
// Module: opnd_ctrl
// Sequencer and operand registers. It accepts a decoded instruction when
// idle, optionally reads the source register, runs zero to two memory hops
// (the first hop's data becomes the second hop's address) and writes the
// result. Assumes the memory returns data one cycle after a request and
// that the register-file read is combinational.
module opnd_ctrl
    import opnd_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int ADDR_W    = 10,
    parameter int REG_IDX_W = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 legal,
    input  logic                 use_src,
    input  logic [1:0]           hops,
    input  logic [REG_IDX_W-1:0] dst_idx,
    input  logic [REG_IDX_W-1:0] src_idx,
    input  logic [ADDR_W-1:0]    addr_fld,
    input  logic [DATA_W-1:0]    imm_val,
    input  logic [OFF_W-1:0]     off_val,
    output logic                 mem_rd_en,
    output logic [ADDR_W-1:0]    mem_addr,
    input  logic [DATA_W-1:0]    mem_rd_data,
    output logic [REG_IDX_W-1:0] rf_rd_idx,
    input  logic [DATA_W-1:0]    rf_rd_data,
    output logic                 rf_we,
    output logic [REG_IDX_W-1:0] rf_wr_idx,
    output logic [DATA_W-1:0]    rf_wr_data,
    output logic                 done
);

    ctrl_state_e          state_q;
    logic [REG_IDX_W-1:0] dst_q;
    logic [REG_IDX_W-1:0] src_q;
    logic [OFF_W-1:0]     off_q;
    logic [1:0]           hops_q;
    logic [ADDR_W-1:0]    addr_q;
    logic [DATA_W-1:0]    data_q;
    logic [ADDR_W-1:0]    reg_addr;
    logic                 accept;

    // Register-based address: source register value plus latched offset.
    opnd_addr_gen #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) addr_gen_i (
        .base     (rf_rd_data),
        .offset   (off_q),
        .eff_addr (reg_addr)
    );

    // Start is taken only in idle and only for a legal mode.
    always_comb accept = (state_q == ST_IDLE) && start && legal;

    // Sequencer state and operand registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            dst_q   <= '0;
            src_q   <= '0;
            off_q   <= '0;
            hops_q  <= '0;
            addr_q  <= '0;
            data_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        dst_q  <= dst_idx;
                        src_q  <= src_idx;
                        off_q  <= off_val;
                        hops_q <= hops;
                        addr_q <= addr_fld;
                        data_q <= imm_val;
                        if (use_src)          state_q <= ST_SRC;
                        else if (hops != 2'd0) state_q <= ST_ISSUE;
                        else                  state_q <= ST_WRITE;
                    end
                end
                ST_SRC: begin
                    if (hops_q == 2'd0) begin
                        data_q  <= rf_rd_data;
                        state_q <= ST_WRITE;
                    end else begin
                        addr_q  <= reg_addr;
                        state_q <= ST_ISSUE;
                    end
                end
                ST_ISSUE: begin
                    hops_q  <= hops_q - 2'd1;
                    state_q <= ST_RETURN;
                end
                ST_RETURN: begin
                    if (hops_q != 2'd0) begin
                        addr_q  <= mem_rd_data[ADDR_W-1:0];
                        state_q <= ST_ISSUE;
                    end else begin
                        data_q  <= mem_rd_data;
                        state_q <= ST_WRITE;
                    end
                end
                ST_WRITE: state_q <= ST_IDLE;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    // Port drive from the current state and operand registers.
    always_comb begin
        mem_rd_en  = (state_q == ST_ISSUE);
        mem_addr   = addr_q;
        rf_rd_idx  = src_q;
        rf_we      = (state_q == ST_WRITE);
        rf_wr_idx  = dst_q;
        rf_wr_data = data_q;
        done       = (state_q == ST_WRITE);
    end

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    rd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> !mem_rd_en);

    // R3
    ptr_hop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RETURN && hops_q != 2'd0) |=>
        (mem_rd_en && mem_addr == $past(mem_rd_data[ADDR_W-1:0])));

    // R9
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && start) |=> ($stable(dst_q) && $stable(src_q)));

    // R10
    bad_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start && !legal) |=> (state_q == ST_IDLE));

    // R1
    imm_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !use_src && hops == 2'd0) |=> (done && !mem_rd_en));

endmodule

// File: rtl/opnd_resolve_unit.sv
// Module: opnd_resolve_unit (top)
// Operand addressing unit: decodes an instruction under one of six
// addressing modes, performs the register and memory reads it needs and
// writes the operand to the destination register with a done pulse.
// Assumes an external register file and a one-cycle-latency memory.
module opnd_resolve_unit
    import opnd_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int ADDR_W    = 10,
    parameter int REG_IDX_W = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [DATA_W-1:0]    instr,
    input  logic [MODE_W-1:0]    mode,
    output logic                 mem_rd_en,
    output logic [ADDR_W-1:0]    mem_addr,
    input  logic [DATA_W-1:0]    mem_rd_data,
    output logic [REG_IDX_W-1:0] rf_rd_idx,
    input  logic [DATA_W-1:0]    rf_rd_data,
    output logic                 rf_we,
    output logic [REG_IDX_W-1:0] rf_wr_idx,
    output logic [DATA_W-1:0]    rf_wr_data,
    output logic                 done
);

    logic                 legal;
    logic                 use_src;
    logic [1:0]           hops;
    logic [REG_IDX_W-1:0] dst_idx;
    logic [REG_IDX_W-1:0] src_idx;
    logic [ADDR_W-1:0]    addr_fld;
    logic [DATA_W-1:0]    imm_val;
    logic [OFF_W-1:0]     off_val;

    opnd_decode #(
        .DATA_W    (DATA_W),
        .ADDR_W    (ADDR_W),
        .REG_IDX_W (REG_IDX_W)
    ) decode_i (
        .instr    (instr),
        .mode     (mode),
        .legal    (legal),
        .use_src  (use_src),
        .hops     (hops),
        .dst_idx  (dst_idx),
        .src_idx  (src_idx),
        .addr_fld (addr_fld),
        .imm_val  (imm_val),
        .off_val  (off_val)
    );

    opnd_ctrl #(
        .DATA_W    (DATA_W),
        .ADDR_W    (ADDR_W),
        .REG_IDX_W (REG_IDX_W)
    ) ctrl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .legal       (legal),
        .use_src     (use_src),
        .hops        (hops),
        .dst_idx     (dst_idx),
        .src_idx     (src_idx),
        .addr_fld    (addr_fld),
        .imm_val     (imm_val),
        .off_val     (off_val),
        .mem_rd_en   (mem_rd_en),
        .mem_addr    (mem_addr),
        .mem_rd_data (mem_rd_data),
        .rf_rd_idx   (rf_rd_idx),
        .rf_rd_data  (rf_rd_data),
        .rf_we       (rf_we),
        .rf_wr_idx   (rf_wr_idx),
        .rf_wr_data  (rf_wr_data),
        .done        (done)
    );

    // R11
    rst_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!done && !rf_we && !mem_rd_en));

endmodule

// File: tb/opnd_resolve_unit_tb.sv
`timescale 1ns/1ps
// Bench: table-driven pass over all modes, then directed tests for reset,
// busy-start rejection and illegal modes. Models the memory and registers.
module opnd_resolve_unit_tb_top;

    typedef struct packed {
        logic [2:0]  mode;
        logic [15:0] instr;
        logic [1:0]  idx;
        logic [15:0] val;
        logic [3:0]  lat;
        logic [1:0]  reads;
    } vec_t;

    // Expected values follow the requirements, applied in table order.
    localparam int NVEC = 12;
    localparam vec_t VECS [NVEC] = '{
        '{3'd1, 16'h23AB, 2'd0, 16'h03AB, 4'd1, 2'd0},
        '{3'd1, 16'h2FFF, 2'd3, 16'h03FF, 4'd1, 2'd0},
        '{3'd0, 16'h1923, 2'd2, 16'h5B23, 4'd3, 2'd1},
        '{3'd2, 16'h1405, 2'd1, 16'h1234, 4'd5, 2'd2},
        '{3'd3, 16'h3200, 2'd2, 16'h03AB, 4'd2, 2'd0},
        '{3'd4, 16'h4010, 2'd0, 16'h5C34, 4'd4, 2'd1},
        '{3'd5, 16'h533F, 2'd3, 16'h5A0E, 4'd4, 2'd1},
        '{3'd5, 16'h5125, 2'd1, 16'h5DB0, 4'd4, 2'd1},
        '{3'd4, 16'h4207, 2'd2, 16'h5A34, 4'd4, 2'd1},
        '{3'd3, 16'h3110, 2'd1, 16'h5DB0, 4'd2, 2'd0},
        '{3'd0, 16'h13FF, 2'd0, 16'h5DFF, 4'd3, 2'd1},
        '{3'd2, 16'h1C40, 2'd3, 16'h5C34, 4'd5, 2'd2}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] instr = '0;
    logic [2:0]  mode = '0;
    logic        mem_rd_en;
    logic [9:0]  mem_addr;
    logic [15:0] mem_rd_data;
    logic [1:0]  rf_rd_idx;
    logic [15:0] rf_rd_data;
    logic        rf_we;
    logic [1:0]  rf_wr_idx;
    logic [15:0] rf_wr_data;
    logic        done;

    logic [15:0] mem [1024];
    logic [15:0] regs [4] = '{16'h1111, 16'h03FE, 16'h8123, 16'h0010};
    logic [15:0] mem_q = '0;
    int          rd_total = 0;
    int          done_total = 0;
    int          n_checks = 0;
    int          n_fail = 0;
    bit          finished = 1'b0;

    always #2.5 clk = ~clk;

    opnd_resolve_unit dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .instr       (instr),
        .mode        (mode),
        .mem_rd_en   (mem_rd_en),
        .mem_addr    (mem_addr),
        .mem_rd_data (mem_rd_data),
        .rf_rd_idx   (rf_rd_idx),
        .rf_rd_data  (rf_rd_data),
        .rf_we       (rf_we),
        .rf_wr_idx   (rf_wr_idx),
        .rf_wr_data  (rf_wr_data),
        .done        (done)
    );

    always @(posedge clk) if (mem_rd_en) mem_q <= mem[mem_addr];
    assign mem_rd_data = mem_q;
    always @(posedge clk) if (rf_we) regs[rf_wr_idx] <= rf_wr_data;
    assign rf_rd_data = regs[rf_rd_idx];
    always @(posedge clk) if (mem_rd_en) rd_total <= rd_total + 1;
    always @(posedge clk) if (done) done_total <= done_total + 1;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic string req_of(input logic [2:0] m);
        case (m)
            3'd0:    return "R2";
            3'd1:    return "R1";
            3'd2:    return "R3";
            3'd3:    return "R4";
            3'd4:    return "R5";
            default: return "R6";
        endcase
    endfunction

    // Issues one instruction from a negedge; returns latency, write index and reads.
    task automatic issue(input logic [2:0] m, input logic [15:0] ins,
                         output int lat, output logic [1:0] widx, output int rds);
        int base;
        base  = rd_total;
        start = 1'b1;
        mode  = m;
        instr = ins;
        @(negedge clk);
        start = 1'b0;
        lat   = 1;
        while (!done && lat < 12) begin
            @(negedge clk);
            lat++;
        end
        widx = rf_wr_idx;
        @(negedge clk);
        rds = rd_total - base;
    endtask

    initial begin
        #(5.0 * 20000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int lat;
        int rds;
        int d0;
        logic [1:0] widx;
        for (int i = 0; i < 1024; i++) mem[i] = 16'h5A00 + 16'(i);
        mem[10'h005] = 16'hFC40;
        mem[10'h040] = 16'h1234;

        // R11: outputs quiet while in reset.
        repeat (3) @(negedge clk);
        check("R11", "done in reset", {31'd0, done}, 32'd0);
        check("R11", "rf_we in reset", {31'd0, rf_we}, 32'd0);
        check("R11", "mem_rd_en in reset", {31'd0, mem_rd_en}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk over all six modes.
        for (int v = 0; v < NVEC; v++) begin
            issue(VECS[v].mode, VECS[v].instr, lat, widx, rds);
            check(req_of(VECS[v].mode), "latency", 32'(lat), 32'(VECS[v].lat));
            check(req_of(VECS[v].mode), "write index", {30'd0, widx}, {30'd0, VECS[v].idx});
            check(req_of(VECS[v].mode), "value", {16'd0, regs[VECS[v].idx]}, {16'd0, VECS[v].val});
            check("R7", "read count", 32'(rds), 32'(VECS[v].reads));
            check("R8", "done single", {31'd0, done}, 32'd0);
        end
        // Registers now: r0=5DFF r1=5DB0 r2=5A34 r3=5C34

        // R9: immediate start while an indirect load is in progress.
        d0 = done_total;
        start = 1'b1; mode = 3'd2; instr = 16'h1005;
        @(negedge clk);
        mode = 3'd1; instr = 16'h2477;
        @(negedge clk);
        start = 1'b0;
        repeat (8) @(negedge clk);
        check("R9", "done count", 32'(done_total - d0), 32'd1);
        check("R9", "indirect result", {16'd0, regs[0]}, 32'h1234);
        check("R9", "busy start target untouched", {16'd0, regs[1]}, 32'h5DB0);

        // R10: illegal modes 6 and 7 are dropped.
        for (int k = 6; k < 8; k++) begin
            d0 = done_total;
            rds = rd_total;
            start = 1'b1; mode = 3'(k); instr = 16'h2055;
            @(negedge clk);
            start = 1'b0;
            repeat (6) @(negedge clk);
            check("R10", "no done", 32'(done_total - d0), 32'd0);
            check("R10", "no reads", 32'(rd_total - rds), 32'd0);
            check("R10", "register untouched", {16'd0, regs[0]}, 32'h1234);
        end
        issue(3'd1, 16'h2812, lat, widx, rds);
        check("R10", "ready after illegal", 32'(lat), 32'd1);
        check("R1", "value after illegal", {16'd0, regs[2]}, 32'h0012);

        // R11: reset in the middle of an indirect load drops it.
        d0 = done_total;
        start = 1'b1; mode = 3'd2; instr = 16'h1C05;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R11", "done mid reset", {31'd0, done}, 32'd0);
        check("R11", "read mid reset", {31'd0, mem_rd_en}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
        check("R11", "no write after reset", 32'(done_total - d0), 32'd0);
        check("R11", "target untouched", {16'd0, regs[3]}, 32'h5C34);
        issue(3'd1, 16'h2C21, lat, widx, rds);
        check("R11", "works after reset", {16'd0, regs[3]}, 32'h0021);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule